// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block sits between a serial receiver's byte deserializer and a byte-wide register read port. It keeps up to `DEPTH` received bytes (four by default) and hands them out oldest first. The read port works as pop-on-read: the oldest byte is always visible on `rd_data`, and a one-cycle `rd_en` strobe consumes it. Three flags are driven from the stored state: `rx_ready` (at least one byte held), `fifo_full` (`DEPTH` bytes held) and `can_accept`. The deserializer may hand over a byte only while `can_accept` is high.

A line-break event puts a zero byte into the queue and sets a sticky break-change flag. A separate strobe clears that flag. If the queue is full when a break arrives, the zero byte replaces the newest stored byte, so the break is never lost. A flush strobe, driven by the receiver-reset command, empties the queue.

The fill level is tracked by a three-state machine:
- `FILL_EMPTY`: no bytes held.
- `FILL_PARTIAL`: between one and `DEPTH`-1 bytes held.
- `FILL_FULL`: `DEPTH` bytes held.

The transitions are:
- **fill_start**: `FILL_EMPTY` to `FILL_PARTIAL`, on any push.
- **fill_top**: `FILL_PARTIAL` to `FILL_FULL`, when the count reaches `DEPTH`.
- **drain_last**: `FILL_PARTIAL` to `FILL_EMPTY`, when the last byte is popped.
- **drain_top**: `FILL_FULL` to `FILL_PARTIAL`, on a pop with no push.
- **flush_all**: any state to `FILL_EMPTY`, on `flush`.

`FILL_FULL` holds its state on a break overwrite and on a pop and push in the same cycle.

Top module: `rxq_holding_buffer`

## Requirements
- R1: Bytes leave in the order they were stored, and up to `DEPTH` (default 4) bytes are held at once.
- R2: While the queue is empty, `rd_data` is 0, and an `rd_en` strobe changes no flag and no stored state.
- R3: While the queue is non-empty, `rd_data` shows the oldest byte. An `rd_en` strobe removes it at the next clock edge, which clears `fifo_full`, and also clears `rx_ready` if no byte remains.
- R4: A byte on `push_data` with `push_valid` high is stored at the clock edge when `can_accept` is high. After that edge `rx_ready` is 1, and `fifo_full` is 1 once `DEPTH` bytes are held.
- R5: `can_accept` equals `rx_enable` AND NOT `fifo_full`. A `push_valid` strobe while `can_accept` is low stores nothing.
- R6: `brk_event` stores a zero byte and sets `brk_flag` whatever the value of `rx_enable`. In the same cycle it takes precedence over `push_valid`, and that data byte is dropped.
- R7: `brk_event` with the queue full and no `rd_en` overwrites the newest byte with 0. The count stays at `DEPTH` and the older bytes are unchanged.
- R8: An accepted push and a pop in the same cycle both take effect, and the count is unchanged.
- R9: `flush` empties the queue at the next edge, clearing `rx_ready` and `fifo_full`. It overrides any push, break push or pop in that cycle, and it leaves `brk_flag` unchanged.
- R10: `brk_clr` clears `brk_flag`, but a `brk_event` in the same cycle wins and the flag stays set.
- R11: After reset the queue is empty, and `rd_data`, `rx_ready`, `fifo_full` and `brk_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receiver enabled |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | DATA_W | Offered byte |
| brk_event | input | 1 | Line-break detected, one-cycle strobe |
| brk_clr | input | 1 | Clear break-change flag |
| flush | input | 1 | Empty the queue (receiver reset) |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | DATA_W | Oldest byte, or 0 when empty |
| rx_ready | output | 1 | At least one byte held |
| fifo_full | output | 1 | DEPTH bytes held |
| can_accept | output | 1 | Deserializer may deliver a byte |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
Every stored effect (push, pop, break insertion or overwrite, flush, flag set and clear) is due on the flags, `brk_flag` and `rd_data` one clock edge after its strobe, because the queue state has a single register stage. `can_accept` is the exception: it follows `rx_enable` in the same cycle. The bench drives inputs on the falling edge and compares all five outputs against a queue-based model shortly afterwards. It then advances the model at the rising edge, so each comparison sees exactly the effect of the strobes from the previous cycle. Directed sequences hit the empty read, full-queue break, pop-with-push and flush-over-everything corners before a long randomized stretch.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } rxq_fill_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_word = slot_q[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic             push_valid,
    input  logic             brk_event,
    input  logic             brk_clr,
    input  logic             flush,
    input  logic             rd_en,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic             wr_zero,
    output logic [PTR_W-1:0] rd_idx,
    output logic             empty,
    output logic             full,
    output logic             can_accept,
    output logic             brk_flag
);
    rxq_fill_e        state_q, state_d;
    logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             brk_q;
    logic             do_pop, do_data, do_ovw, do_append;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    // Output process: flags and strobes decoded from the fill state.
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            FILL_EMPTY:   empty = 1'b1;
            FILL_PARTIAL: ;
            FILL_FULL:    full  = 1'b1;
            default:      empty = 1'b1;
        endcase
        can_accept = rx_enable && !full;
        do_pop     = rd_en && !empty;
        do_data    = push_valid && can_accept && !brk_event;
        do_ovw     = brk_event && full && !do_pop;
        do_append  = (brk_event && !do_ovw) || do_data;
        wr_en      = !flush && (do_append || do_ovw);
        wr_idx     = do_ovw ? ptr_dec(wptr_q) : wptr_q;
        wr_zero    = brk_event;
        rd_idx     = rptr_q;
        brk_flag   = brk_q;
    end

    // Next-state process: pointers, count and fill-state transitions.
    always_comb begin
        if (flush) begin
            rptr_d = '0;
            wptr_d = '0;
            cnt_d  = '0;
        end else begin
            rptr_d = do_pop ? ptr_inc(rptr_q) : rptr_q;
            wptr_d = do_append ? ptr_inc(wptr_q) : wptr_q;
            cnt_d  = cnt_q + CNT_W'(do_append) - CNT_W'(do_pop);
        end
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY:   if (cnt_d != '0) state_d = FILL_PARTIAL;               // fill_start
            FILL_PARTIAL: if (cnt_d == '0) state_d = FILL_EMPTY;                 // drain_last / flush_all
                          else if (cnt_d == CNT_W'(DEPTH)) state_d = FILL_FULL;  // fill_top
            FILL_FULL:    if (cnt_d == '0) state_d = FILL_EMPTY;                 // flush_all
                          else if (cnt_d != CNT_W'(DEPTH)) state_d = FILL_PARTIAL; // drain_top
            default:      state_d = FILL_EMPTY;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            rptr_q  <= '0;
            wptr_q  <= '0;
            cnt_q   <= '0;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rptr_q  <= rptr_d;
            wptr_q  <= wptr_d;
            cnt_q   <= cnt_d;
            if (brk_event)    brk_q <= 1'b1;
            else if (brk_clr) brk_q <= 1'b0;
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    assert_empty_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !push_valid && !brk_event && !flush)
        |=> (state_q == FILL_EMPTY) && $stable(rptr_q) && $stable(wptr_q));

    assert_brk_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_event |=> brk_flag);

    assert_full_break_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && brk_event && !rd_en && !flush)
        |=> (state_q == FILL_FULL) && $stable(rptr_q) && $stable(wptr_q));

    assert_pop_push_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && do_pop && do_append) |=> $stable(cnt_q));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == FILL_EMPTY) && (cnt_q == '0));
endmodule

// File: rtl/rxq_holding_buffer.sv
module rxq_holding_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              brk_event,
    input  logic              brk_clr,
    input  logic              flush,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              can_accept,
    output logic              brk_flag
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             wr_en, wr_zero, empty;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [DATA_W-1:0] head_word;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .push_valid (push_valid),
        .brk_event  (brk_event),
        .brk_clr    (brk_clr),
        .flush      (flush),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_zero    (wr_zero),
        .rd_idx     (rd_idx),
        .empty      (empty),
        .full       (fifo_full),
        .can_accept (can_accept),
        .brk_flag   (brk_flag)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_zero ? '0 : push_data),
        .rd_idx  (rd_idx),
        .rd_word (head_word)
    );

    assign rd_data  = empty ? '0 : head_word;
    assign rx_ready = !empty;

    assert_full_blocks_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !can_accept);

    assert_empty_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (rd_data == '0));
endmodule

// File: tb/rxq_holding_buffer_tb_top.sv
module rxq_holding_buffer_tb_top;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_enable = 1'b0, push_valid = 1'b0, brk_event = 1'b0;
    logic brk_clr = 1'b0, flush = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic rx_ready, fifo_full, can_accept, brk_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [DATA_W-1:0] mq[$];
    logic m_brk = 1'b0;

    always #4 clk = ~clk;

    rxq_holding_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .push_valid(push_valid),
        .push_data(push_data), .brk_event(brk_event), .brk_clr(brk_clr),
        .flush(flush), .rd_en(rd_en), .rd_data(rd_data), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .can_accept(can_accept), .brk_flag(brk_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int exp_d;
        exp_d = (mq.size() == 0) ? 0 : int'(mq[0]);
        check(tag, "rd_data R1/R3", int'(rd_data), exp_d);
        check(tag, "rx_ready R3", int'(rx_ready), int'(mq.size() != 0));
        check(tag, "fifo_full R4", int'(fifo_full), int'(mq.size() == DEPTH));
        check(tag, "can_accept R5", int'(can_accept), int'(rx_enable && mq.size() != DEPTH));
        check(tag, "brk_flag R10", int'(brk_flag), int'(m_brk));
    endtask

    // One cycle: drive at falling edge, compare, then advance model at the rising edge.
    task automatic step(input string tag, input logic en, input logic pv, input logic [7:0] pd,
                        input logic bk, input logic bc, input logic fl, input logic rd);
        bit pop, full;
        @(negedge clk);
        rx_enable = en; push_valid = pv; push_data = pd;
        brk_event = bk; brk_clr = bc; flush = fl; rd_en = rd;
        #1;
        compare_all(tag);
        @(posedge clk);
        full = (mq.size() == DEPTH);
        pop  = rd && (mq.size() != 0);
        if (fl) begin
            mq.delete();
        end else if (bk) begin
            if (full && !pop) mq[DEPTH-1] = '0;
            else begin
                if (pop) void'(mq.pop_front());
                mq.push_back('0);
            end
        end else begin
            if (pop) void'(mq.pop_front());
            if (pv && en && !full) mq.push_back(pd);
        end
        if (bk) m_brk = 1'b1;
        else if (bc) m_brk = 1'b0;
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        #3;
        compare_all("R11 in reset");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 state after reset, R2 empty reads
        step("R11", 1, 0, 8'h00, 0, 0, 0, 0);
        step("R2", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R2", 1, 0, 8'h00, 0, 0, 0, 1);
        // R4 / R1: store three, read in order
        step("R4", 1, 1, 8'hA1, 0, 0, 0, 0);
        step("R4", 1, 1, 8'hB2, 0, 0, 0, 0);
        step("R4", 1, 1, 8'hC3, 0, 0, 0, 0);
        step("R3", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R3", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R3", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R2", 1, 0, 8'h00, 0, 0, 0, 1);
        // fill to DEPTH, push while full ignored (R5)
        for (int i = 0; i < DEPTH; i++) step("R1", 1, 1, 8'h10 + 8'(i), 0, 0, 0, 0);
        step("R5", 1, 1, 8'hEE, 0, 0, 0, 0);
        step("R5", 1, 1, 8'hEF, 0, 0, 0, 1);
        // R7 break while full overwrites newest
        step("R7", 1, 0, 8'h00, 1, 0, 0, 0);
        step("R7", 1, 0, 8'h00, 0, 0, 0, 0);
        // R8 break while full with pop: normal append
        step("R8", 1, 0, 8'h00, 1, 0, 0, 1);
        for (int i = 0; i < DEPTH + 1; i++) step("R1", 1, 0, 8'h00, 0, 0, 0, 1);
        // R10 clear and clear-vs-set
        step("R10", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R10", 1, 0, 8'h00, 1, 1, 0, 0);
        step("R10", 1, 0, 8'h00, 0, 1, 0, 1);
        // R5 disabled receiver ignores data, R6 break still stored and wins over data
        step("R5", 0, 1, 8'h55, 0, 0, 0, 0);
        step("R6", 0, 1, 8'h66, 1, 0, 0, 0);
        step("R6", 1, 1, 8'h77, 1, 0, 0, 0);
        step("R6", 1, 0, 8'h00, 0, 0, 0, 0);
        // R8 simultaneous pop and push
        step("R8", 1, 1, 8'h88, 0, 0, 0, 1);
        step("R8", 1, 1, 8'h99, 0, 0, 0, 1);
        // R9 flush overrides everything, brk_flag kept
        step("R9", 1, 1, 8'hAA, 0, 0, 0, 0);
        step("R9", 1, 1, 8'hAB, 0, 0, 0, 0);
        step("R9", 1, 1, 8'hAC, 1, 0, 1, 1);
        step("R9", 1, 0, 8'h00, 0, 0, 0, 0);
        // randomized stretch
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step("rand", ($urandom % 8) != 0, r[0], 8'($urandom), ($urandom % 12) == 0,
                 ($urandom % 10) == 0, ($urandom % 40) == 0, r[1] & r[2]);
        end
        step("end", 1, 0, 8'h00, 0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule